// File: doc/BRIEF.md
# NAND Read-Retry Register Sequencer

This block moves a NAND flash device to a requested read-retry level. It writes a set of private device registers through an abstract command/address/data bus. A host presents a mode index and a one-cycle start request. The sequencer opens a parameter-set window with a command byte. It writes each tuning register as an address cycle carrying the register offset, followed immediately by a data-out cycle carrying the value for that mode. It then closes the window with an apply command.

The per-mode values are stored in an internal byte table, filled beforehand through a simple write port. The value for register i of mode m sits at table index m*NUM_REGS + i. The register offsets come from a parameter list and are visited in list order. Every bus cycle is held until the downstream side accepts it. A bus error ends the sequence at once.

Top module: `nand_rr_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o and bus_valid_o are all low.
- R2: An accepted request first issues a command cycle (bus_kind_o = 2'b00) carrying byte 0x36. busy_o rises in the cycle after the request and stays high until the last command is accepted.
- R3: Each register is written as exactly one address cycle (bus_kind_o = 2'b01) followed directly by one data-out cycle (bus_kind_o = 2'b10). No command cycle comes between them.
- R4: The address cycles carry the register offsets in list order. The default list is 0xCC, 0xBF, 0xAA, 0xAB, 0xCD, 0xAD, 0xAE, 0xAF.
- R5: The data cycle for register i in mode m carries table entry m*NUM_REGS + i.
- R6: The sequence ends with a command cycle carrying 0x16. In the cycle after it is accepted, done_o pulses high for exactly one cycle and busy_o is low.
- R7: While bus_valid_o is high and bus_ready_i is low, the bus kind and byte stay unchanged.
- R8: A request with mode_i at or above NUM_MODES (default 8) produces a one-cycle err_o pulse. It issues no bus cycle and does not raise busy_o or done_o.
- R9: bus_err_i high during a valid bus cycle ends the sequence. No further cycles are issued, the apply command is skipped, err_o pulses once and done_o stays low.
- R10: A write through the table port changes the value sent by later sequences for that mode and register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start request, sampled when idle |
| mode_i | input | 4 | Requested retry mode index |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when the sequence completes |
| err_o | output | 1 | One-cycle pulse on a rejected request or a bus abort |
| tbl_we_i | input | 1 | Table write enable |
| tbl_waddr_i | input | 6 | Table write index |
| tbl_wdata_i | input | 8 | Table write value |
| bus_valid_o | output | 1 | Bus cycle presented |
| bus_kind_o | output | 2 | 00 command, 01 address, 10 data out |
| bus_byte_o | output | 8 | Byte carried by the bus cycle |
| bus_ready_i | input | 1 | Downstream accepts the cycle |
| bus_err_i | input | 1 | Downstream reports a bus error |

## Verification
The first and last modes are run with bus_ready_i held high. This catches index and offset errors at both ends of the table. A middle mode is run with ready arriving only every third cycle, which shows whether the cycles are held steady and whether stalls corrupt the pairing of addresses and data. An out-of-range mode and an error injected partway through tell a clean rejection apart from a silent run or a partial run that still applies. A rerun after a table rewrite separates a live table lookup from stale values.

// File: rtl/nand_rr_pkg.sv
package nand_rr_pkg;
  typedef enum logic [1:0] {
    BK_CMD  = 2'b00,
    BK_ADDR = 2'b01,
    BK_DOUT = 2'b10
  } bus_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ENTER,
    ST_ADDR,
    ST_DATA,
    ST_APPLY
  } seq_state_e;

  localparam logic [7:0] CMD_ENTER = 8'h36;
  localparam logic [7:0] CMD_APPLY = 8'h16;
endpackage

// File: rtl/nand_rr_table.sv
module nand_rr_table #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/nand_rr_ctrl.sv
module nand_rr_ctrl
  import nand_rr_pkg::*;
#(
  parameter int NUM_REGS  = 8,
  parameter int NUM_MODES = 8,
  parameter logic [NUM_REGS*8-1:0] REG_OFFS = 64'hAFAE_ADCD_ABAA_BFCC,
  localparam int MW = $clog2(NUM_MODES) + 1,
  localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int AW = $clog2(NUM_MODES * NUM_REGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [MW-1:0] mode_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [AW-1:0] tbl_raddr_o,
  input  logic [7:0]    tbl_rdata_i,
  output logic          bus_valid_o,
  output logic [1:0]    bus_kind_o,
  output logic [7:0]    bus_byte_o,
  input  logic          bus_ready_i,
  input  logic          bus_err_i
);
  seq_state_e    state_q;
  logic [MW-1:0] mode_q;
  logic [IW-1:0] idx_q;
  logic          done_q, err_q;

  logic mode_bad;
  assign mode_bad = mode_i >= MW'(NUM_MODES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (req_i) begin
          if (mode_bad) err_q <= 1'b1;
          else begin
            mode_q  <= mode_i;
            idx_q   <= '0;
            state_q <= ST_ENTER;
          end
        end
      end else if (bus_err_i) begin
        // abort: drop everything, apply never issued
        state_q <= ST_IDLE;
        err_q   <= 1'b1;
      end else if (bus_ready_i) begin
        unique case (state_q)
          ST_ENTER: state_q <= ST_ADDR;
          ST_ADDR:  state_q <= ST_DATA;
          ST_DATA: begin
            if (idx_q == IW'(NUM_REGS - 1)) state_q <= ST_APPLY;
            else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_ADDR;
            end
          end
          ST_APPLY: begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign tbl_raddr_o = AW'(mode_q) * AW'(NUM_REGS) + AW'(idx_q);

  always_comb begin
    bus_kind_o = BK_CMD;
    bus_byte_o = CMD_ENTER;
    unique case (state_q)
      ST_ADDR: begin
        bus_kind_o = BK_ADDR;
        bus_byte_o = REG_OFFS[idx_q*8 +: 8];
      end
      ST_DATA: begin
        bus_kind_o = BK_DOUT;
        bus_byte_o = tbl_rdata_i;
      end
      ST_APPLY: bus_byte_o = CMD_APPLY;
      default: ;
    endcase
  end

  assign bus_valid_o = state_q != ST_IDLE;
  assign busy_o      = state_q != ST_IDLE;
  assign done_o      = done_q;
  assign err_o       = err_q;

  a_r7_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && !bus_ready_i && !bus_err_i |=>
      bus_valid_o && $stable(bus_kind_o) && $stable(bus_byte_o));

  a_r2_first_enter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> bus_kind_o == BK_CMD && bus_byte_o == CMD_ENTER);

  a_r6_done_after_apply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(bus_kind_o) == BK_CMD && $past(bus_byte_o) == CMD_APPLY);

  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r3_addr_then_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && bus_kind_o == BK_ADDR && bus_ready_i && !bus_err_i |=>
      bus_kind_o == BK_DOUT);

  a_r8_reject_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && req_i && mode_bad |=> err_o && !busy_o);

  a_r9_abort_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && bus_err_i |=> !bus_valid_o && err_o && !done_o);
endmodule

// File: rtl/nand_rr_seq.sv
module nand_rr_seq #(
  parameter int NUM_REGS  = 8,
  parameter int NUM_MODES = 8,
  parameter logic [NUM_REGS*8-1:0] REG_OFFS = 64'hAFAE_ADCD_ABAA_BFCC,
  localparam int MW = $clog2(NUM_MODES) + 1,
  localparam int DEPTH = NUM_MODES * NUM_REGS,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [MW-1:0] mode_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  input  logic          tbl_we_i,
  input  logic [AW-1:0] tbl_waddr_i,
  input  logic [7:0]    tbl_wdata_i,
  output logic          bus_valid_o,
  output logic [1:0]    bus_kind_o,
  output logic [7:0]    bus_byte_o,
  input  logic          bus_ready_i,
  input  logic          bus_err_i
);
  logic [AW-1:0] tbl_raddr;
  logic [7:0]    tbl_rdata;

  nand_rr_table #(.DEPTH(DEPTH)) u_table (
    .clk_i   (clk_i),
    .we_i    (tbl_we_i),
    .waddr_i (tbl_waddr_i),
    .wdata_i (tbl_wdata_i),
    .raddr_i (tbl_raddr),
    .rdata_o (tbl_rdata)
  );

  nand_rr_ctrl #(
    .NUM_REGS (NUM_REGS),
    .NUM_MODES(NUM_MODES),
    .REG_OFFS (REG_OFFS)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .mode_i      (mode_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .tbl_raddr_o (tbl_raddr),
    .tbl_rdata_i (tbl_rdata),
    .bus_valid_o (bus_valid_o),
    .bus_kind_o  (bus_kind_o),
    .bus_byte_o  (bus_byte_o),
    .bus_ready_i (bus_ready_i),
    .bus_err_i   (bus_err_i)
  );
endmodule

// File: tb/nand_rr_seq_tb.sv
`timescale 1ns/1ps
module nand_rr_seq_tb;
  logic clk = 0, rst_n = 0;
  logic req = 0;
  logic [3:0] mode = 0;
  logic busy, done, err;
  logic we = 0;
  logic [5:0] waddr = 0;
  logic [7:0] wdata = 0;
  logic bvalid;
  logic [1:0] bkind;
  logic [7:0] bbyte;
  logic bready = 0, berr = 0;

  int tests = 0, fails = 0;
  int cyc = 0, div = 1, err_at = 1000, acc_cnt = 0;
  logic [1:0] log_k [64];
  logic [7:0] log_b [64];
  logic [7:0] offs [8] = '{8'hCC, 8'hBF, 8'hAA, 8'hAB, 8'hCD, 8'hAD, 8'hAE, 8'hAF};
  logic [7:0] vals [64];

  always #10 clk = ~clk;

  nand_rr_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .mode_i(mode),
    .busy_o(busy), .done_o(done), .err_o(err),
    .tbl_we_i(we), .tbl_waddr_i(waddr), .tbl_wdata_i(wdata),
    .bus_valid_o(bvalid), .bus_kind_o(bkind), .bus_byte_o(bbyte),
    .bus_ready_i(bready), .bus_err_i(berr)
  );

  always @(posedge clk) begin
    if (rst_n && bvalid && bready && !berr && acc_cnt < 64) begin
      log_k[acc_cnt] <= bkind;
      log_b[acc_cnt] <= bbyte;
      acc_cnt <= acc_cnt + 1;
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    bready <= ((cyc % div) == 0);
    berr <= 1'b0;
  end

  // error injection reacts to the current valid cycle
  always @(negedge clk) begin
    #1;
    if (bvalid && acc_cnt == err_at) berr = 1'b1;
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: act=%0d exp<=100000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string rq, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic write_tbl(input int a, input logic [7:0] v);
    @(negedge clk);
    we = 1; waddr = 6'(a); wdata = v;
    @(negedge clk);
    we = 0;
    vals[a] = v;
  endtask

  // runs one request; returns counts of done/err pulses
  task automatic run(input int m, input int d, input int ea,
                     output int n_done, output int n_err, output int max_busy_gap);
    n_done = 0; n_err = 0; max_busy_gap = 0;
    @(negedge clk);
    div = d; err_at = ea; acc_cnt = 0;
    req = 1; mode = 4'(m);
    @(negedge clk);
    req = 0;
    for (int k = 0; k < 600; k++) begin
      if (done) n_done++;
      if (err) n_err++;
      if (done && busy) max_busy_gap++;
      @(negedge clk);
      if (k > 3 && !busy && !done && !err && (n_done + n_err) > 0) break;
    end
    repeat (3) @(negedge clk);
    chk("R9 no trailing cycles", int'(bvalid), 0);
    err_at = 1000; div = 1;
  endtask

  task automatic check_full(input string rq, input int m);
    chk({rq, " count"}, acc_cnt, 18);
    chk("R2 enter kind", log_k[0], 0);
    chk("R2 enter byte", log_b[0], 8'h36);
    for (int i = 0; i < 8; i++) begin
      chk("R3 addr kind", log_k[1 + 2*i], 1);
      chk("R4 offset", log_b[1 + 2*i], offs[i]);
      chk("R3 data kind", log_k[2 + 2*i], 2);
      chk("R5 value", log_b[2 + 2*i], vals[m*8 + i]);
    end
    chk("R6 apply kind", log_k[17], 0);
    chk("R6 apply byte", log_b[17], 8'h16);
  endtask

  task automatic t_reset();
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 valid", int'(bvalid), 0);
  endtask

  task automatic t_mode(input int m, input int d, input string rq);
    int nd, ne, g;
    run(m, d, 1000, nd, ne, g);
    check_full(rq, m);
    chk("R6 done once", nd, 1);
    chk("R6 busy low at done", g, 0);
    chk("R6 no err", ne, 0);
  endtask

  task automatic t_reject();
    int nd, ne, g;
    run(8, 1, 1000, nd, ne, g);
    chk("R8 no bus cycles", acc_cnt, 0);
    chk("R8 err once", ne, 1);
    chk("R8 no done", nd, 0);
  endtask

  task automatic t_abort();
    int nd, ne, g;
    run(2, 1, 5, nd, ne, g);
    chk("R9 cycles before abort", acc_cnt, 5);
    chk("R9 err once", ne, 1);
    chk("R9 no done", nd, 0);
    for (int i = 0; i < 5; i++)
      chk("R9 no apply", int'(log_k[i] == 2'b00 && log_b[i] == 8'h16), 0);
  endtask

  task automatic t_rewrite();
    write_tbl(0*8 + 3, 8'hE7);
    t_mode(0, 1, "R10 rewrite");
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    for (int a = 0; a < 64; a++) write_tbl(a, 8'((a * 37 + 11) & 255));
    t_mode(0, 1, "R5 first mode");
    t_mode(7, 1, "R5 last mode");
    t_mode(3, 3, "R7 stalled");
    t_reject();
    t_abort();
    t_mode(1, 2, "R7 after abort");
    t_rewrite();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule